// File: doc/BRIEF.md
# Shared Memory Bank Conflict Resolver

This block takes one request from a group of 32 lanes. A request is 32 word addresses plus a mask of the lanes that take part. The block works out which of the 32 four-byte banks each lane touches, and then breaks the request into the smallest number of serialized passes. In any one pass, a bank delivers at most one distinct word. Every lane that wants that same word is served in the same pass, because the word is broadcast to all of them. A request whose lanes all fall in different banks therefore finishes in one pass.

Passes leave the block one per beat over a valid/ready handshake. Each beat carries the mask of lanes served in that pass and a flag that marks the final pass. When the final pass has been handed off, the block raises a one-cycle completion pulse. At that point the pass counter holds the number of passes the request needed. A new request is taken only after the current one is complete. The storage arrays and any merging of write data belong to the surrounding logic.

Top module: `bank_conflict_resolver`

## Requirements
- R1: The bank of a lane is its word address modulo 32, which is the low 5 bits of the address. The remaining high bits select the word within that bank.
- R2: When every active lane maps to a different bank, the request is served in a single beat. That beat carries all active lanes and has `pass_last`=1.
- R3: Lanes that request the same word are served in the same beat (broadcast), and this costs no extra pass.
- R4: In each pass, every bank serves the word of its lowest-numbered still-pending lane, together with every other pending lane that requests that same word. Distinct words in the same bank are therefore served in later passes.
- R5: The one-cycle `done` pulse appears on the clock edge that hands off the final beat. At that point `pass_total` equals the largest number of distinct words requested in any single bank.
- R6: A request with an all-zero mask produces no beat. `done` is raised on the edge that accepts the request, and `pass_total` reads 0.
- R7: Inactive lanes never appear in any `pass_lanes` mask, and they do not cause conflicts with active lanes.
- R8: `req_ready` is low from the acceptance of a request with a non-zero mask until its final beat is handed off. Requests presented during that time are ignored.
- R9: While `pass_valid` is high and `pass_ready` is low, `pass_lanes` and `pass_last` hold steady.
- R10: After reset, `req_ready`=1, `pass_valid`=0, `done`=0 and `pass_total`=0.
- R11: `pass_last` is 1 only on the final beat of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can accept a request |
| req_addr | input | LANES*AW | Word address of each lane; lane i uses bits [i*AW +: AW] |
| req_mask | input | LANES | Active lanes, one bit per lane |
| pass_valid | output | 1 | A pass beat is presented |
| pass_ready | input | 1 | The consumer takes the beat |
| pass_lanes | output | LANES | Lanes served in this pass |
| pass_last | output | 1 | This beat is the final pass of the request |
| pass_total | output | $clog2(LANES+1) | Number of passes handed off for the current request |
| done | output | 1 | One-cycle pulse when the request is complete |

## Verification
The request is accepted on the first rising edge at which `req_valid` and `req_ready` are both high. The first beat is registered one edge after that, and with `pass_ready` held high a new beat follows on every edge. `done` and the final `pass_total` become visible on the edge that hands off the final beat. For an all-zero mask they become visible on the edge that accepts the request.

The bench drives its inputs and samples the outputs at the falling edge. It records each beat at the falling edge where it sees `pass_valid` together with the `pass_ready` it has just driven. It then expects `done` at the very next falling edge after the final handoff. When `pass_ready` is stalled at random, the bench compares the beat it sees against the one it saw at the previous falling edge.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int DEF_LANES = 32;
  localparam int DEF_BANKS = 32;
  localparam int DEF_AW    = 10;
endpackage

// File: rtl/bcr_bank_map.sv
module bcr_bank_map #(
  parameter int LANES = bcr_pkg::DEF_LANES,
  parameter int BANKS = bcr_pkg::DEF_BANKS,
  parameter int AW    = bcr_pkg::DEF_AW,
  localparam int BW   = $clog2(BANKS),
  localparam int TW   = AW - BW
) (
  input  logic [LANES*AW-1:0] addr_flat,
  output logic [LANES*BW-1:0] bank_flat,
  output logic [LANES*TW-1:0] tag_flat
);
  // Low bits pick the bank (word address modulo BANKS), high bits the row.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign bank_flat[i*BW +: BW] = addr_flat[i*AW +: BW];
    assign tag_flat[i*TW +: TW]  = addr_flat[i*AW+BW +: TW];
  end
endmodule

// File: rtl/bcr_pass_pick.sv
module bcr_pass_pick #(
  parameter int LANES = bcr_pkg::DEF_LANES,
  parameter int BW    = 5,
  parameter int TW    = 5
) (
  input  logic [LANES*BW-1:0] bank_flat,
  input  logic [LANES*TW-1:0] tag_flat,
  input  logic [LANES-1:0]    pending,
  output logic [LANES-1:0]    served
);
  logic [LANES-1:0] leader;

  // Leader of a bank: lowest pending lane mapped to it.
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      leader[j] = pending[j];
      for (int k = 0; k < j; k++)
        if (pending[k] && bank_flat[k*BW +: BW] == bank_flat[j*BW +: BW])
          leader[j] = 1'b0;
    end
  end

  // A pending lane goes now unless a lower leader of its bank wants another row.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      served[i] = pending[i];
      for (int j = 0; j < i; j++)
        if (leader[j] && bank_flat[j*BW +: BW] == bank_flat[i*BW +: BW]
            && tag_flat[j*TW +: TW] != tag_flat[i*TW +: TW])
          served[i] = 1'b0;
    end
  end
endmodule

// File: rtl/bank_conflict_resolver.sv
module bank_conflict_resolver #(
  parameter int LANES = bcr_pkg::DEF_LANES,
  parameter int BANKS = bcr_pkg::DEF_BANKS,
  parameter int AW    = bcr_pkg::DEF_AW,
  localparam int BW   = $clog2(BANKS),
  localparam int TW   = AW - BW,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_mask,
  output logic                pass_valid,
  input  logic                pass_ready,
  output logic [LANES-1:0]    pass_lanes,
  output logic                pass_last,
  output logic [CW-1:0]       pass_total,
  output logic                done
);
  logic                busy;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    mask_q, pend_q, served, remain;
  logic [LANES*BW-1:0] bank_flat;
  logic [LANES*TW-1:0] tag_flat;
  logic                accept, handoff, issue;

  bcr_bank_map #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) u_map (
    .addr_flat(addr_q), .bank_flat(bank_flat), .tag_flat(tag_flat)
  );

  bcr_pass_pick #(.LANES(LANES), .BW(BW), .TW(TW)) u_pick (
    .bank_flat(bank_flat), .tag_flat(tag_flat), .pending(pend_q), .served(served)
  );

  assign remain    = pend_q & ~served;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign handoff   = pass_valid && pass_ready;
  assign issue     = busy && (pend_q != '0) && (!pass_valid || pass_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      addr_q     <= '0;
      mask_q     <= '0;
      pend_q     <= '0;
      pass_valid <= 1'b0;
      pass_lanes <= '0;
      pass_last  <= 1'b0;
      pass_total <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        addr_q     <= req_addr;
        mask_q     <= req_mask;
        pend_q     <= req_mask;
        busy       <= |req_mask;
        pass_total <= '0;
        done       <= ~|req_mask;
      end
      if (issue) begin
        pass_valid <= 1'b1;
        pass_lanes <= served;
        pass_last  <= (remain == '0);
        pend_q     <= remain;
      end else if (handoff) begin
        pass_valid <= 1'b0;
      end
      if (handoff) begin
        pass_total <= pass_total + 1'b1;
        if (pass_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_INACTIVE_NEVER_SERVED: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> ((pass_lanes & ~mask_q) == '0)); // R7
  AST_PASS_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> (pass_lanes != '0)); // R4
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
    (pass_valid && !pass_ready) |=> (pass_valid && $stable(pass_lanes) && $stable(pass_last))); // R9
  AST_NO_ACCEPT_WHILE_BEAT: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> !req_ready); // R8
  AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && !pass_valid)); // R5
  AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> (pass_total < CW'(LANES))); // R5
endmodule

// File: tb/bank_conflict_resolver_bench.sv
module bank_conflict_resolver_bench;
  localparam int LANES = 32;
  localparam int AW    = 10;
  localparam int CW    = $clog2(LANES + 1);
  localparam int CLK_PERIOD = 10;

  logic                clk = 1'b0;
  logic                rst;
  logic                req_valid;
  logic                req_ready;
  logic [LANES*AW-1:0] req_addr;
  logic [LANES-1:0]    req_mask;
  logic                pass_valid;
  logic                pass_ready;
  logic [LANES-1:0]    pass_lanes;
  logic                pass_last;
  logic [CW-1:0]       pass_total;
  logic                done;

  int errors = 0;
  int checks = 0;

  logic [AW-1:0]    cur_addr [LANES];
  logic [LANES-1:0] cur_mask;
  logic [LANES-1:0] exp_pass [LANES+1];
  int               exp_n;
  int               exp_max;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_conflict_resolver #(.LANES(LANES), .BANKS(32), .AW(AW)) u_bank_conflict_resolver (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .pass_valid(pass_valid),
    .pass_ready(pass_ready), .pass_lanes(pass_lanes), .pass_last(pass_last),
    .pass_total(pass_total), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Expected pass sequence: per bank, lowest pending lane's word plus all sharers.
  task automatic build_model();
    logic [LANES-1:0] pend;
    pend  = cur_mask;
    exp_n = 0;
    while (pend != '0) begin
      logic [LANES-1:0] sv;
      sv = '0;
      for (int b = 0; b < 32; b++) begin
        int lead;
        lead = -1;
        for (int l = 0; l < LANES; l++)
          if (lead < 0 && pend[l] && (cur_addr[l] % 32) == b) lead = l;
        if (lead >= 0)
          for (int l = 0; l < LANES; l++)
            if (pend[l] && cur_addr[l] == cur_addr[lead]) sv[l] = 1'b1;
      end
      exp_pass[exp_n] = sv;
      pend = pend & ~sv;
      exp_n++;
    end
    // Independent count: largest number of distinct words in one bank.
    exp_max = 0;
    for (int b = 0; b < 32; b++) begin
      int cnt;
      cnt = 0;
      for (int l = 0; l < LANES; l++) begin
        bit seen;
        seen = 1'b0;
        if (cur_mask[l] && (cur_addr[l] % 32) == b) begin
          for (int m = 0; m < l; m++)
            if (cur_mask[m] && cur_addr[m] == cur_addr[l]) seen = 1'b1;
          if (!seen) cnt++;
        end
      end
      if (cnt > exp_max) exp_max = cnt;
    end
  endtask

  task automatic run_req(input bit stall, input string tag);
    int  k;
    int  guard;
    bit  held, finished, handed_last;
    logic [LANES-1:0] h_lanes;
    logic             h_last;
    build_model();
    chk(exp_n == exp_max, {tag, " R5 model"}, 64'(exp_n), 64'(exp_max));
    @(negedge clk);
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = cur_addr[l];
    req_mask  = cur_mask;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, {tag, " R8 ready idle"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    if (cur_mask == '0) begin
      req_valid = 1'b0;
      chk(done == 1'b1, {tag, " R6 done"}, 64'(done), 64'd1);
      chk(pass_total == 0, {tag, " R6 total"}, 64'(pass_total), 64'd0);
      chk(pass_valid == 1'b0, {tag, " R6 no beat"}, 64'(pass_valid), 64'd0);
      @(negedge clk);
      chk(pass_valid == 1'b0 && done == 1'b0, {tag, " R6 quiet"}, 64'({pass_valid, done}), 64'd0);
      return;
    end
    // Junk request held while busy must be ignored (R8).
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = AW'($urandom);
    req_mask = LANES'($urandom);
    k = 0; guard = 0; held = 0; finished = 0; handed_last = 0;
    h_lanes = '0; h_last = 0;
    while (!finished && guard < 500) begin
      guard++;
      if (handed_last) begin
        chk(done == 1'b1, {tag, " R5 done"}, 64'(done), 64'd1);
        chk(pass_total == CW'(exp_n), {tag, " R5 total"}, 64'(pass_total), 64'(exp_n));
        req_valid = 1'b0;
        finished  = 1;
      end else begin
        if (req_ready !== 1'b0) chk(1'b0, {tag, " R8 ready busy"}, 64'(req_ready), 64'd0);
        if (done !== 1'b0) chk(1'b0, {tag, " R5 early done"}, 64'(done), 64'd0);
        if (held)
          chk(pass_valid && pass_lanes == h_lanes && pass_last == h_last,
              {tag, " R9 hold"}, 64'(pass_lanes), 64'(h_lanes));
        if (pass_valid) begin
          bit r;
          r = stall ? 1'($urandom % 2) : 1'b1;
          pass_ready = r;
          if (r) begin
            if (k < exp_n)
              chk(pass_lanes == exp_pass[k], {tag, " R4 lanes"}, 64'(pass_lanes), 64'(exp_pass[k]));
            else
              chk(1'b0, {tag, " R4 extra beat"}, 64'(k), 64'(exp_n));
            chk(pass_last == (k == exp_n - 1), {tag, " R11 last"}, 64'(pass_last), 64'(k == exp_n - 1));
            chk((pass_lanes & ~cur_mask) == '0, {tag, " R7 inactive"}, 64'(pass_lanes), 64'(cur_mask));
            k++;
            if (pass_last) handed_last = 1;
            held = 0;
          end else begin
            held = 1; h_lanes = pass_lanes; h_last = pass_last;
          end
        end else begin
          held = 0;
        end
        @(negedge clk);
      end
    end
    if (!finished) chk(1'b0, {tag, " R5 never done"}, 64'(k), 64'(exp_n));
    pass_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_mask = '0; pass_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1 && pass_valid == 1'b0 && done == 1'b0 && pass_total == 0,
        "R10 reset", 64'({req_ready, pass_valid, done, pass_total}), 64'({1'b1, 1'b0, 1'b0, CW'(0)}));

    // R2 and R1: distinct banks, high bits varied -> one pass
    for (int l = 0; l < LANES; l++) cur_addr[l] = AW'(l + 32 * ((l * 7) % 32));
    cur_mask = '1;
    run_req(0, "R2 distinct");
    chk(exp_n == 1, "R2 one pass", 64'(exp_n), 64'd1);

    // R3 broadcast: every lane the same word
    for (int l = 0; l < LANES; l++) cur_addr[l] = AW'(77);
    cur_mask = '1;
    run_req(0, "R3 broadcast");

    // R1 and R4: all in bank 5, all rows distinct -> 32 passes
    for (int l = 0; l < LANES; l++) cur_addr[l] = AW'(32 * l + 5);
    cur_mask = '1;
    run_req(1, "R1 same bank");
    chk(exp_n == 32, "R1 pass count", 64'(exp_n), 64'd32);

    // R6 empty mask
    cur_mask = '0;
    run_req(0, "R6 empty");

    // R7 inactive lanes conflicting with active ones
    for (int l = 0; l < LANES; l++) cur_addr[l] = (l % 2 == 0) ? AW'(3) : AW'(32 * l + 3);
    cur_mask = 32'h5555_5555;
    run_req(0, "R7 inactive");
    chk(exp_n == 1, "R7 one pass", 64'(exp_n), 64'd1);

    // R3 with R4: mixture of sharers and conflicts in one bank
    for (int l = 0; l < LANES; l++) cur_addr[l] = AW'(32 * (l % 3) + 9);
    cur_mask = '1;
    run_req(1, "R3 mixed");

    // Random requests
    void'($urandom(32'd1234));
    for (int t = 0; t < 60; t++) begin
      int range;
      case ($urandom % 3)
        0: range = 64;
        1: range = 256;
        default: range = 1024;
      endcase
      for (int l = 0; l < LANES; l++) cur_addr[l] = AW'($urandom % range);
      cur_mask = ($urandom % 4 == 0) ? LANES'($urandom) : '1;
      run_req(1'(t % 2), "R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule